// File: doc/BRIEF.md
# Self-Timed Page Program and Erase Engine

This block sits behind the serial command decoder of a small flash-style memory. After a program command and its start address, it collects incoming data bytes into a one-page staging buffer. The column pointer starts at the column given by the address and wraps inside the page. When the chip-select rise that ends the transaction arrives on a byte boundary, the engine commits the staged bytes into the array model in one step. It then holds busy for a time that scales with the number of bytes staged.

The engine also accepts sector erase and whole-array erase commands. A sector erase picks its half of the array from the top address bit, so any address inside the sector selects it. An erased byte reads FFh. A program can only clear bits, because the stored value becomes the old byte ANDed with the new one.

Every write is gated in two places. The write-enable state is sampled when the command arrives, and the lock input from the protection logic is sampled at the chip-select rise. When the busy period ends, the engine pulses a request that clears the write-enable latch. All delays are counters, and their lengths are parameters in clock cycles.

Top module: `pgm_engine`

## Requirements
- R1: After reset busy_o and wel_clr_o are 0, arr_prog_o and arr_erase_o are 0, and every array byte reads FFh on rd_data_o.
- R2: A committed program stores (old AND new) at page base plus column for each supplied byte, where the page comes from addr_i[ADDR_W-1:PAGE_W] and the start column from addr_i[PAGE_W-1:0]. Bytes of the page that were not supplied keep their contents.
- R3: Each byte_valid_i advances the column by one, and the column wraps from 2^PAGE_W-1 to 0 within the same page. A later byte landing on an already-filled column replaces the earlier buffered byte.
- R4: A program commits only when cs_rise_i arrives with cs_aligned_i=1 and at least one byte has been buffered. Any other cs_rise_i ends the command with no array change and no busy.
- R5: A program, sector erase or chip erase command seen while wel_i=0 is ignored: the array is unchanged, no strobe is raised and busy stays 0.
- R6: A sector erase sets to FFh every byte whose address bit ADDR_W-1 equals addr_i[ADDR_W-1] at the command. The other sector is unchanged.
- R7: A chip erase sets every array byte to FFh.
- R8: busy_o rises in the cycle after the committing cs_rise_i. It stays high for N*T_BYTE cycles for a program of N distinct columns, T_SECT cycles for a sector erase and T_CHIP cycles for a chip erase.
- R9: wel_clr_o is a one-cycle pulse in the first cycle after busy_o falls.
- R10: If lock_i=1 at the ending cs_rise_i, the operation is cancelled: no strobe, no busy and no array change.
- R11: While busy_o=1, commands, bytes and chip-select rises are ignored and leave the array unchanged.
- R12: arr_prog_o (for a program) or arr_erase_o (for an erase) is high for exactly the committing cycle, the one in which the accepted cs_rise_i is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_cmd_i | input | 1 | Program command with address decoded (one-cycle pulse) |
| sect_cmd_i | input | 1 | Sector erase command with address decoded (one-cycle pulse) |
| chip_cmd_i | input | 1 | Chip erase command decoded (one-cycle pulse) |
| addr_i | input | ADDR_W | Address accompanying the command |
| wel_i | input | 1 | Write-enable latch state |
| lock_i | input | 1 | Array locked by protection logic |
| byte_valid_i | input | 1 | A full data byte has been received |
| byte_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select has risen (one-cycle pulse) |
| cs_aligned_i | input | 1 | The chip-select rise fell on a byte boundary |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |
| arr_prog_o | output | 1 | Program commit strobe |
| arr_erase_o | output | 1 | Erase commit strobe |
| busy_o | output | 1 | Self-timed cycle in progress |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |

## Verification
The bench builds the block with ADDR_W=9 and PAGE_W=7. This gives four 128-byte pages and two 256-byte sectors, so both the in-page wrap and the difference between sector and chip erase can be observed on a small array. It sets T_BYTE=3, T_SECT=40 and T_CHIP=80, so the exact busy length of a 128-column program (384 cycles) and of both erase kinds can be counted cycle by cycle. It also leaves a busy window long enough to issue a complete program command inside it.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARM,
    ST_RUN
  } eng_state_e;
endpackage

// File: rtl/pgm_page_buf.sv
module pgm_page_buf #(
  parameter int PAGE_W = 7,
  localparam int PAGE = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic [PAGE_W-1:0] col_i,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  output logic [PAGE*8-1:0] data_o,
  output logic [PAGE-1:0]   mask_o,
  output logic [PAGE_W:0]   cnt_o
);
  logic [PAGE_W-1:0] col_q;
  logic [PAGE-1:0]   mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      mask_q <= '0;
    end else if (open_i) begin
      col_q  <= col_i;
      mask_q <= '0;
    end else if (push_i) begin
      col_q         <= col_q + 1'b1;  // natural wrap inside page
      mask_q[col_q] <= 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    localparam logic [PAGE_W-1:0] COL = PAGE_W'(i);
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= 8'hFF;
      else if (push_i && !open_i && col_q == COL) slot_q <= byte_i;
    end
    assign data_o[i*8 +: 8] = slot_q;
  end

  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < PAGE; k++) cnt_o = cnt_o + (PAGE_W+1)'(mask_q[k]);
  end

  assign mask_o = mask_q;

  // R3
  col_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !open_i && col_q == {PAGE_W{1'b1}}) |=> (col_q == '0));
endmodule

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         run_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign run_o  = (cnt_q != '0);
  assign done_o = (cnt_q == W'(1));

  // R11
  no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_o);
endmodule

// File: rtl/pgm_array.sv
module pgm_array #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PAGE  = 1 << PAGE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [PAGE*8-1:0] data_i,
  input  logic [PAGE-1:0]   mask_i,
  input  logic              erase_i,
  input  logic              chip_i,
  input  logic              sect_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [DEPTH*8-1:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [PG_W-1:0] PG  = PG_W'(i >> PAGE_W);
    localparam int              COL = i % PAGE;
    localparam logic            SEC = ((i >> (ADDR_W-1)) & 1) != 0;
    logic [7:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cell_q <= 8'hFF;
      else if (erase_i && (chip_i || sect_i == SEC)) cell_q <= 8'hFF;
      else if (prog_i && page_i == PG && mask_i[COL])
        cell_q <= cell_q & data_i[COL*8 +: 8];  // program only clears bits
    end
    assign cells[i*8 +: 8] = cell_q;
  end

  assign rd_data_o = cells[rd_addr_i*8 +: 8];

  // R12
  one_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_i && erase_i));
endmodule

// File: rtl/pgm_engine.sv
module pgm_engine
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7,
  parameter int T_BYTE = 75,
  parameter int T_SECT = 1000,
  parameter int T_CHIP = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_cmd_i,
  input  logic              sect_cmd_i,
  input  logic              chip_cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wel_i,
  input  logic              lock_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              arr_prog_o,
  output logic              arr_erase_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  localparam int PAGE     = 1 << PAGE_W;
  localparam int PG_W     = ADDR_W - PAGE_W;
  localparam int PROG_MAX = PAGE * T_BYTE;
  localparam int MAX_A    = (PROG_MAX > T_SECT) ? PROG_MAX : T_SECT;
  localparam int MAX_T    = (MAX_A > T_CHIP) ? MAX_A : T_CHIP;
  localparam int TMR_W    = $clog2(MAX_T + 1);

  eng_state_e        state_q, state_d;
  logic              chip_q, sect_q, wel_clr_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE*8-1:0] buf_data;
  logic [PAGE-1:0]   buf_mask;
  logic [PAGE_W:0]   buf_cnt;
  logic              open, push, fire, go_prog, go_erase;
  logic              tmr_run, tmr_done;
  logic [TMR_W-1:0]  tmr_val;

  assign fire     = cs_rise_i && cs_aligned_i && !lock_i;
  assign open     = (state_q == ST_IDLE) && prog_cmd_i && wel_i;
  assign push     = (state_q == ST_FILL) && byte_valid_i;
  assign go_prog  = (state_q == ST_FILL) && fire && (buf_cnt != '0);
  assign go_erase = (state_q == ST_ARM) && fire;

  always_comb begin
    if (go_prog)     tmr_val = TMR_W'(buf_cnt) * TMR_W'(T_BYTE);
    else if (chip_q) tmr_val = TMR_W'(T_CHIP);
    else             tmr_val = TMR_W'(T_SECT);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (wel_i && prog_cmd_i)                     state_d = ST_FILL;
        else if (wel_i && (sect_cmd_i || chip_cmd_i)) state_d = ST_ARM;
      end
      ST_FILL, ST_ARM: begin
        if (go_prog || go_erase) state_d = ST_RUN;
        else if (cs_rise_i)      state_d = ST_IDLE;
      end
      ST_RUN: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      chip_q    <= 1'b0;
      sect_q    <= 1'b0;
      page_q    <= '0;
      wel_clr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wel_clr_q <= (state_q == ST_RUN) && tmr_done;
      if (state_q == ST_IDLE) begin
        if (open) page_q <= addr_i[ADDR_W-1:PAGE_W];
        if (wel_i && !prog_cmd_i && (sect_cmd_i || chip_cmd_i)) begin
          chip_q <= !sect_cmd_i;
          sect_q <= addr_i[ADDR_W-1];
        end
      end
    end
  end

  pgm_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (open),
    .col_i  (addr_i[PAGE_W-1:0]),
    .push_i (push),
    .byte_i (byte_i),
    .data_o (buf_data),
    .mask_o (buf_mask),
    .cnt_o  (buf_cnt)
  );

  pgm_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go_prog || go_erase),
    .val_i  (tmr_val),
    .run_o  (tmr_run),
    .done_o (tmr_done)
  );

  pgm_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_i    (go_prog),
    .page_i    (page_q),
    .data_i    (buf_data),
    .mask_i    (buf_mask),
    .erase_i   (go_erase),
    .chip_i    (chip_q),
    .sect_i    (sect_q),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign arr_prog_o  = go_prog;
  assign arr_erase_o = go_erase;
  assign busy_o      = (state_q == ST_RUN);
  assign wel_clr_o   = wel_clr_q;

  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(arr_prog_o || arr_erase_o));
  // R8
  busy_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> tmr_run);
  // R9
  wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> wel_clr_o);
  // R9
  wel_clr_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wel_clr_o);
  // R11
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(arr_prog_o || arr_erase_o));
  // R10
  commit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_prog_o || arr_erase_o) |-> (cs_rise_i && !lock_i));
endmodule

// File: tb/pgm_engine_bench.sv
module pgm_engine_bench;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog_cmd = 0, sect_cmd = 0, chip_cmd = 0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic          wel = 0, lock = 0, bvalid = 0, cs_rise = 0, cs_al = 0;
  logic [7:0]    bdata = '0;
  logic [7:0]    rd_data;
  logic          arr_prog, arr_erase, busy, wel_clr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pgm_engine #(.ADDR_W(AW), .PAGE_W(7), .T_BYTE(3), .T_SECT(40), .T_CHIP(80)) u_pgm_engine (
    .clk_i(clk), .rst_ni(rst_n), .prog_cmd_i(prog_cmd), .sect_cmd_i(sect_cmd),
    .chip_cmd_i(chip_cmd), .addr_i(addr), .wel_i(wel), .lock_i(lock),
    .byte_valid_i(bvalid), .byte_i(bdata), .cs_rise_i(cs_rise), .cs_aligned_i(cs_al),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .arr_prog_o(arr_prog),
    .arr_erase_o(arr_erase), .busy_o(busy), .wel_clr_o(wel_clr));

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(int kind, int a, bit w);
    @(negedge clk);
    addr = AW'(a); wel = w;
    prog_cmd = (kind == 0); sect_cmd = (kind == 1); chip_cmd = (kind == 2);
    @(posedge clk);
    @(negedge clk);
    prog_cmd = 0; sect_cmd = 0; chip_cmd = 0;
  endtask

  task automatic push_byte(logic [7:0] b);
    @(negedge clk);
    bvalid = 1; bdata = b;
    @(posedge clk);
    @(negedge clk);
    bvalid = 0;
  endtask

  task automatic end_cs(bit al, bit lk, output bit sp, output bit se);
    @(negedge clk);
    cs_rise = 1; cs_al = al; lock = lk;
    #1;
    sp = arr_prog; se = arr_erase;
    @(posedge clk);
    @(negedge clk);
    cs_rise = 0; cs_al = 0; lock = 0;
  endtask

  task automatic wait_busy(output int n, output bit clr);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    clr = wel_clr;
  endtask

  task automatic rd(int a, output int d);
    rd_addr = AW'(a);
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    int d;
    check("R1", "busy after reset", busy, 0);
    check("R1", "wel_clr after reset", wel_clr, 0);
    check("R1", "strobes after reset", {arr_prog, arr_erase}, 0);
    rd(9'h000, d); check("R1", "mem[000]", d, 8'hFF);
    rd(9'h1FF, d); check("R1", "mem[1FF]", d, 8'hFF);
  endtask

  task automatic t_prog_basic();
    bit sp, se, clr; int n, d;
    cmd(0, 9'h005, 1);
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0);
    end_cs(1, 0, sp, se);
    check("R12", "arr_prog strobe", sp, 1);
    check("R12", "no erase strobe", se, 0);
    check("R8", "busy rises after cs", busy, 1);
    wait_busy(n, clr);
    check("R8", "busy length 3 bytes", n, 9);
    check("R9", "wel_clr pulse", clr, 1);
    @(negedge clk);
    check("R9", "wel_clr one cycle", wel_clr, 0);
    rd(9'h005, d); check("R2", "mem[005]", d, 8'hA5);
    rd(9'h006, d); check("R2", "mem[006]", d, 8'h3C);
    rd(9'h007, d); check("R2", "mem[007]", d, 8'hF0);
    rd(9'h004, d); check("R2", "mem[004] untouched", d, 8'hFF);
    rd(9'h008, d); check("R2", "mem[008] untouched", d, 8'hFF);
  endtask

  task automatic t_and();
    bit sp, se, clr; int n, d;
    cmd(0, 9'h005, 1);
    push_byte(8'h0F);
    end_cs(1, 0, sp, se);
    wait_busy(n, clr);
    check("R8", "busy length 1 byte", n, 3);
    rd(9'h005, d); check("R2", "AND of old and new", d, 8'h05);
    rd(9'h006, d); check("R2", "neighbour kept", d, 8'h3C);
  endtask

  task automatic t_wrap();
    bit sp, se, clr; int n, d;
    cmd(0, 9'h0FE, 1);
    for (int i = 0; i < 130; i++) push_byte(8'(i));
    end_cs(1, 0, sp, se);
    check("R12", "wrap program strobe", sp, 1);
    wait_busy(n, clr);
    check("R8", "busy length full page", n, 384);
    rd(9'h0FE, d); check("R3", "col 126 overwritten", d, 8'h80);
    rd(9'h0FF, d); check("R3", "col 127 overwritten", d, 8'h81);
    rd(9'h080, d); check("R3", "col 0 after wrap", d, 8'h02);
    rd(9'h081, d); check("R3", "col 1 after wrap", d, 8'h03);
    rd(9'h100, d); check("R3", "next page untouched", d, 8'hFF);
    rd(9'h07F, d); check("R3", "previous page untouched", d, 8'hFF);
  endtask

  task automatic t_discard();
    bit sp, se; int d;
    cmd(0, 9'h010, 1);
    push_byte(8'h00);
    end_cs(0, 0, sp, se);
    check("R4", "misaligned no strobe", sp, 0);
    check("R4", "misaligned no busy", busy, 0);
    rd(9'h010, d); check("R4", "misaligned no write", d, 8'hFF);
    cmd(0, 9'h011, 1);
    end_cs(1, 0, sp, se);
    check("R4", "empty program no strobe", sp, 0);
    check("R4", "empty program no busy", busy, 0);
  endtask

  task automatic t_nowel();
    bit sp, se; int d;
    cmd(0, 9'h020, 0);
    push_byte(8'h00);
    end_cs(1, 0, sp, se);
    check("R5", "no wel program strobe", sp, 0);
    check("R5", "no wel program busy", busy, 0);
    rd(9'h020, d); check("R5", "no wel mem[020]", d, 8'hFF);
    cmd(1, 9'h000, 0);
    end_cs(1, 0, sp, se);
    check("R5", "no wel erase strobe", se, 0);
    rd(9'h005, d); check("R5", "no wel erase mem[005]", d, 8'h05);
  endtask

  task automatic t_lock();
    bit sp, se; int d;
    cmd(0, 9'h030, 1);
    push_byte(8'h00);
    end_cs(1, 1, sp, se);
    check("R10", "locked program strobe", sp, 0);
    check("R10", "locked program busy", busy, 0);
    rd(9'h030, d); check("R10", "locked mem[030]", d, 8'hFF);
    cmd(2, 9'h000, 1);
    end_cs(1, 1, sp, se);
    check("R10", "locked erase strobe", se, 0);
    rd(9'h006, d); check("R10", "locked erase mem[006]", d, 8'h3C);
  endtask

  task automatic t_busy_ignore();
    bit sp, se, clr; int n, d;
    cmd(0, 9'h060, 1);
    for (int i = 0; i < 10; i++) push_byte(8'h11);
    end_cs(1, 0, sp, se);
    cmd(0, 9'h070, 1);
    push_byte(8'h00);
    end_cs(1, 0, sp, se);
    check("R11", "no strobe while busy", sp, 0);
    check("R11", "still busy", busy, 1);
    wait_busy(n, clr);
    rd(9'h070, d); check("R11", "mem[070] untouched", d, 8'hFF);
    rd(9'h069, d); check("R2", "mem[069] programmed", d, 8'h11);
  endtask

  task automatic t_sector();
    bit sp, se, clr; int n, d;
    cmd(0, 9'h150, 1);
    push_byte(8'h00);
    end_cs(1, 0, sp, se);
    wait_busy(n, clr);
    rd(9'h150, d); check("R2", "mem[150] programmed", d, 8'h00);
    cmd(1, 9'h1AB, 1);
    end_cs(1, 0, sp, se);
    check("R12", "erase strobe", se, 1);
    check("R12", "no program strobe on erase", sp, 0);
    wait_busy(n, clr);
    check("R8", "sector erase busy length", n, 40);
    check("R9", "wel_clr after erase", clr, 1);
    rd(9'h150, d); check("R6", "sector 1 erased", d, 8'hFF);
    rd(9'h005, d); check("R6", "sector 0 kept mem[005]", d, 8'h05);
    rd(9'h0FE, d); check("R6", "sector 0 kept mem[0FE]", d, 8'h80);
  endtask

  task automatic t_chip();
    bit sp, se, clr; int n, d;
    cmd(2, 9'h000, 1);
    end_cs(1, 0, sp, se);
    check("R12", "chip erase strobe", se, 1);
    wait_busy(n, clr);
    check("R8", "chip erase busy length", n, 80);
    rd(9'h005, d); check("R7", "chip erase mem[005]", d, 8'hFF);
    rd(9'h0FE, d); check("R7", "chip erase mem[0FE]", d, 8'hFF);
    rd(9'h069, d); check("R7", "chip erase mem[069]", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_basic();
    t_and();
    t_wrap();
    t_discard();
    t_nowel();
    t_lock();
    t_busy_ignore();
    t_sector();
    t_chip();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule